// File: doc/BRIEF.md
# State-Enable Register Bank

This block keeps, for one hart, the index-0 state-enable registers of three privilege levels: a 64-bit machine register, a 64-bit hypervisor register and a 32-bit supervisor register. Each set bit allows less-privileged code to reach one piece of extension state. A CSR port decodes the address, applies the write, and returns read data in the same cycle. The effective enable vectors are also driven out to a separate access checker. Trap generation belongs to that checker.

Each stored bit keeps the value it was last written with. Masking by a more-privileged level is applied only where a value is seen, which is the read path and the effective outputs. A bit that is cleared above therefore reads as zero below, and it shows its old value again once it is set above. The supervisor register is also masked by the hypervisor register when it is read from virtualized supervisor mode. In a 32-bit configuration, the machine and hypervisor registers each have a high-half address that holds bits 63..32. Indices 1 to 3 are decoded but hold nothing.

Top module: `stateen_csr_bank`

## Requirements
- R1: After reset every stored bit is zero, so every register reads zero and every effective output is zero.
- R2: The machine register (0x30C) implements bits 0 (custom), 1 (FCSR), 2 (JVT), 56 (delegation), 57 (CONTEXT), 58 (IMSIC), 59 (AIA), 60 (CSRIND), 62 (ENVCFG) and 63 (SE0). Writing all ones reads back 64'hDF00_0000_0000_0007.
- R3: The hypervisor register (0x60C) implements the same bits except 56, and bit 63 is always writable. It reads as its stored value ANDed with the machine view.
- R4: The supervisor register (0x10C) implements bits 0 to 2 only. It reads as its stored value ANDed with the low 32 bits of the machine view.
- R5: When `virt`=1 and `priv`=2'b01 (virtualized supervisor), a supervisor read is also ANDed with the hypervisor view. In any other mode it is not.
- R6: While `f_ext_on`=1, bit 1 reads zero in all three registers and in all effective outputs.
- R7: Stored bits keep their written value. Setting a bit again at a higher level brings back the lower-level value unchanged.
- R8: With XLEN=32, 0x31C and 0x61C access bits 63..32 of the machine and hypervisor registers. With XLEN=64, those addresses are not decoded: they give hit 0, read 0 and ignore writes.
- R9: Indices 1 to 3 (the low two address bits nonzero in each group) give hit 1, read zero and ignore writes.
- R10: `m_eff`, `h_eff`, `s_eff` and `vs_eff` present the machine view, the hypervisor view, the native supervisor view and the supervisor view from virtualized supervisor mode.
- R11: Bits cleared in the implementation-mask parameters read zero at their level and at every level below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| virt | input | 1 | Virtualization flag |
| f_ext_on | input | 1 | F extension active |
| csr_hit | output | 1 | Address names a state-enable register |
| csr_rdata | output | XLEN | Read data |
| m_eff | output | 64 | Effective machine-level enables |
| h_eff | output | 64 | Effective hypervisor-level enables |
| s_eff | output | 32 | Effective supervisor enables, native |
| vs_eff | output | 32 | Effective supervisor enables, virtualized |

## Verification
`csr_rdata` and `csr_hit` are combinational in the address and mode inputs, so the bench checks them in the same cycle the address is driven, after the inputs settle and before the next rising edge. A write becomes visible from the first falling edge after the rising edge that captures it. `f_ext_on`, `virt` and `priv` act on the outputs without any delay. The reference model updates its state on the rising edge, and the comparison against it runs at every falling edge, once the inputs have settled and before they change again.

// File: rtl/stateen_pkg.sv
package stateen_pkg;
  localparam int unsigned SE_W  = 64;
  localparam int unsigned SE_SW = 32;

  localparam int unsigned B_CUSTOM  = 0;
  localparam int unsigned B_FCSR    = 1;
  localparam int unsigned B_JVT     = 2;
  localparam int unsigned B_DELEG   = 56;
  localparam int unsigned B_CONTEXT = 57;
  localparam int unsigned B_IMSIC   = 58;
  localparam int unsigned B_AIA     = 59;
  localparam int unsigned B_CSRIND  = 60;
  localparam int unsigned B_ENVCFG  = 62;
  localparam int unsigned B_SE0     = 63;

  localparam logic [SE_W-1:0] ONE64 = 64'd1;

  localparam logic [SE_W-1:0] LOW_FIELDS =
    (ONE64 << B_CUSTOM) | (ONE64 << B_FCSR) | (ONE64 << B_JVT);
  localparam logic [SE_W-1:0] HYP_FIELDS = LOW_FIELDS |
    (ONE64 << B_CONTEXT) | (ONE64 << B_IMSIC) | (ONE64 << B_AIA) |
    (ONE64 << B_CSRIND) | (ONE64 << B_ENVCFG) | (ONE64 << B_SE0);
  localparam logic [SE_W-1:0] MACH_FIELDS = HYP_FIELDS | (ONE64 << B_DELEG);

  localparam logic [11:0] A_MACH    = 12'h30C;
  localparam logic [11:0] A_MACH_HI = 12'h31C;
  localparam logic [11:0] A_HYP     = 12'h60C;
  localparam logic [11:0] A_HYP_HI  = 12'h61C;
  localparam logic [11:0] A_SUP     = 12'h10C;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_M    = 2'd1,
    LVL_H    = 2'd2,
    LVL_S    = 2'd3
  } se_level_e;

  typedef struct packed {
    se_level_e lvl;
    logic      idx0;
    logic      hi;
  } se_sel_t;
endpackage

// File: rtl/stateen_addr_dec.sv
module stateen_addr_dec
  import stateen_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [11:0] addr,
  output se_sel_t     sel
);
  localparam bit HAS_HI = (XLEN == 32);

  logic [11:0] base;

  always_comb begin
    base     = {addr[11:2], 2'b00};
    sel.lvl  = LVL_NONE;
    sel.hi   = 1'b0;
    sel.idx0 = (addr[1:0] == 2'b00);
    unique case (base)
      A_MACH: sel.lvl = LVL_M;
      A_HYP:  sel.lvl = LVL_H;
      A_SUP:  sel.lvl = LVL_S;
      A_MACH_HI: if (HAS_HI) begin
        sel.lvl = LVL_M;
        sel.hi  = 1'b1;
      end
      A_HYP_HI: if (HAS_HI) begin
        sel.lvl = LVL_H;
        sel.hi  = 1'b1;
      end
      default: sel.lvl = LVL_NONE;
    endcase
  end

  always_comb begin
    // R8: high halves decode only in the 32-bit configuration
    p_hi_only_rv32_r8: assert (!sel.hi || HAS_HI);
  end
endmodule

// File: rtl/stateen_reg.sv
module stateen_reg #(
  parameter int unsigned     W     = 64,
  parameter logic [W-1:0]    WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam int unsigned H     = W / 2;
  localparam logic [W-1:0] LO_M = {{(W-H){1'b0}}, {H{1'b1}}};
  localparam logic [W-1:0] HI_M = ~LO_M;

  logic [W-1:0] q_d;
  logic [W-1:0] sel_m;
  logic         q_en;

  always_comb begin
    sel_m = (({W{we_lo}} & LO_M) | ({W{we_hi}} & HI_M)) & WMASK;
    q_d   = (q & ~sel_m) | (wdata & sel_m);
    q_en  = we_lo | we_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  // R7: with no write strobe the stored value holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_lo || we_hi) |=> $stable(q));
endmodule

// File: rtl/stateen_csr_bank.sv
module stateen_csr_bank
  import stateen_pkg::*;
#(
  parameter int unsigned     XLEN   = 64,
  parameter logic [63:0]     M_IMPL = '1,
  parameter logic [63:0]     H_IMPL = '1,
  parameter logic [31:0]     S_IMPL = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            f_ext_on,
  output logic            csr_hit,
  output logic [XLEN-1:0] csr_rdata,
  output logic [63:0]     m_eff,
  output logic [63:0]     h_eff,
  output logic [31:0]     s_eff,
  output logic [31:0]     vs_eff
);
  localparam logic [63:0] M_WM = M_IMPL & MACH_FIELDS;
  localparam logic [63:0] H_WM = (H_IMPL | (ONE64 << B_SE0)) & HYP_FIELDS;
  localparam logic [31:0] S_WM = S_IMPL & LOW_FIELDS[31:0];
  localparam bit          WIDE = (XLEN == 64);

  se_sel_t     sel;
  logic [63:0] wdata_w;
  logic [63:0] m_q, h_q;
  logic [31:0] s_q;
  logic        wr;
  logic        m_we_lo, m_we_hi, h_we_lo, h_we_hi, s_we;
  logic [63:0] fcsr_kill;
  logic        vs_mode;
  logic [63:0] rd_view;

  stateen_addr_dec #(.XLEN(XLEN)) u_dec (.addr(csr_addr), .sel(sel));

  generate
    if (WIDE) begin : g_w64
      assign wdata_w   = csr_wdata;
      assign csr_rdata = rd_view;
    end else begin : g_w32
      assign wdata_w   = {csr_wdata, csr_wdata};
      assign csr_rdata = sel.hi ? rd_view[63:32] : rd_view[31:0];
    end
  endgenerate

  always_comb begin
    wr      = csr_we & sel.idx0;
    m_we_lo = wr && (sel.lvl == LVL_M) && (WIDE || !sel.hi);
    m_we_hi = wr && (sel.lvl == LVL_M) && (WIDE || sel.hi);
    h_we_lo = wr && (sel.lvl == LVL_H) && (WIDE || !sel.hi);
    h_we_hi = wr && (sel.lvl == LVL_H) && (WIDE || sel.hi);
    s_we    = wr && (sel.lvl == LVL_S);
  end

  stateen_reg #(.W(64), .WMASK(M_WM)) u_mreg (
    .clk(clk), .rst_n(rst_n), .we_lo(m_we_lo), .we_hi(m_we_hi),
    .wdata(wdata_w), .q(m_q));

  stateen_reg #(.W(64), .WMASK(H_WM)) u_hreg (
    .clk(clk), .rst_n(rst_n), .we_lo(h_we_lo), .we_hi(h_we_hi),
    .wdata(wdata_w), .q(h_q));

  stateen_reg #(.W(32), .WMASK(S_WM)) u_sreg (
    .clk(clk), .rst_n(rst_n), .we_lo(s_we), .we_hi(s_we),
    .wdata(wdata_w[31:0]), .q(s_q));

  always_comb begin
    fcsr_kill = f_ext_on ? (ONE64 << B_FCSR) : 64'd0;
    m_eff     = m_q & M_WM & ~fcsr_kill;
    h_eff     = h_q & H_WM & m_eff;
    s_eff     = s_q & S_WM & m_eff[31:0];
    vs_eff    = s_eff & h_eff[31:0];
    vs_mode   = virt && (priv == 2'b01);
    csr_hit   = (sel.lvl != LVL_NONE);
    rd_view   = 64'd0;
    if (sel.idx0) begin
      unique case (sel.lvl)
        LVL_M:   rd_view = m_eff;
        LVL_H:   rd_view = h_eff;
        LVL_S:   rd_view = {32'd0, vs_mode ? vs_eff : s_eff};
        default: rd_view = 64'd0;
      endcase
    end
  end

  // R2: a machine low-half write shows up in the machine view next cycle
  p_m_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == A_MACH && !f_ext_on)
      |=> f_ext_on || m_eff[31:0] == ($past(csr_wdata[31:0]) & M_WM[31:0]));

  // R3: hypervisor bit 63 takes a written one whenever machine bit 63 is set
  p_h63_writable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == A_HYP_HI + (WIDE ? 12'h000 : 12'h000) - (WIDE ? 12'h010 : 12'h000)
       && m_eff[63] && csr_wdata[XLEN-1]) |=> h_eff[63]);

  // R9: writes to indices 1..3 leave every view unchanged
  p_idx_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_hit && !sel.idx0) |=>
      (f_ext_on != $past(f_ext_on)) ||
      ($stable(m_eff) && $stable(h_eff) && $stable(s_eff)));

  // R7: a write aimed at a lower level leaves the machine view alone
  p_m_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && sel.lvl != LVL_M) |=>
      (f_ext_on != $past(f_ext_on)) || $stable(m_eff));

  always_comb begin
    // R8: addresses that are not decoded read zero
    p_nohit_zero_r8: assert (csr_hit || csr_rdata == '0);
    // R6: FCSR enable is off everywhere while the F extension is on
    p_fcsr_off_r6: assert (!f_ext_on || (!m_eff[B_FCSR] && !h_eff[B_FCSR] && !vs_eff[B_FCSR]));
  end
endmodule

// File: tb/stateen_csr_bank_tb_top.sv
module stateen_csr_bank_tb_top;
  localparam logic [63:0] DEF_M = 64'hDF00_0000_0000_0007;
  localparam logic [63:0] DEF_H = 64'hDE00_0000_0000_0007;
  localparam logic [31:0] DEF_S = 32'h0000_0007;
  localparam logic [63:0] IMPL32_M = ~64'h4;

  logic        clk;
  logic        rst_n;
  logic [11:0] addr;
  logic        we;
  logic [63:0] wd;
  logic [1:0]  priv;
  logic        virt;
  logic        fon;

  logic        hit64, hit32;
  logic [63:0] rd64;
  logic [31:0] rd32;
  logic [63:0] me64, he64, me32, he32;
  logic [31:0] se64, ve64, se32, ve32;

  int checks;
  int fails;

  logic [63:0] mr64, hr64, mr32, hr32;
  logic [31:0] sr64, sr32;

  stateen_csr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wd),
    .priv(priv), .virt(virt), .f_ext_on(fon), .csr_hit(hit64), .csr_rdata(rd64),
    .m_eff(me64), .h_eff(he64), .s_eff(se64), .vs_eff(ve64));

  stateen_csr_bank #(.XLEN(32), .M_IMPL(IMPL32_M)) dut32_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wd[31:0]),
    .priv(priv), .virt(virt), .f_ext_on(fon), .csr_hit(hit32), .csr_rdata(rd32),
    .m_eff(me32), .h_eff(he32), .s_eff(se32), .vs_eff(ve32));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] mview(logic [63:0] raw, logic [63:0] impl, logic f);
    return raw & impl & DEF_M & (f ? ~64'h2 : ~64'h0);
  endfunction
  function automatic logic [63:0] hview(logic [63:0] raw, logic [63:0] mv);
    return raw & DEF_H & mv;
  endfunction
  function automatic logic [31:0] sview(logic [31:0] raw, logic [63:0] mv,
                                        logic [63:0] hv, logic vsm);
    return raw & DEF_S & mv[31:0] & (vsm ? hv[31:0] : 32'hFFFF_FFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr64 = '0; hr64 = '0; sr64 = '0; mr32 = '0; hr32 = '0; sr32 = '0;
    end else if (we) begin
      case (addr)
        12'h30C: begin mr64 = wd; mr32[31:0] = wd[31:0]; end
        12'h60C: begin hr64 = wd; hr32[31:0] = wd[31:0]; end
        12'h10C: begin sr64 = wd[31:0]; sr32 = wd[31:0]; end
        12'h31C: mr32[63:32] = wd[31:0];
        12'h61C: hr32[63:32] = wd[31:0];
        default: ;
      endcase
    end
  end

  // per-cycle comparison against the model (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      logic [63:0] m6, h6, m3, h3, e64, e32x;
      logic [31:0] s6, v6, s3, v3;
      logic vsm, eh64, eh32;
      vsm = virt && priv == 2'b01;
      m6 = mview(mr64, '1, fon);   h6 = hview(hr64, m6);
      s6 = sview(sr64, m6, h6, 1'b0); v6 = sview(sr64, m6, h6, 1'b1);
      m3 = mview(mr32, IMPL32_M, fon); h3 = hview(hr32, m3);
      s3 = sview(sr32, m3, h3, 1'b0); v3 = sview(sr32, m3, h3, 1'b1);
      eh64 = (addr[11:2] == 10'h0C3) || (addr[11:2] == 10'h183) || (addr[11:2] == 10'h043);
      eh32 = eh64 || (addr[11:2] == 10'h0C7) || (addr[11:2] == 10'h187);
      case (addr)
        12'h30C: begin e64 = m6; e32x = {32'd0, m3[31:0]}; end
        12'h60C: begin e64 = h6; e32x = {32'd0, h3[31:0]}; end
        12'h10C: begin e64 = {32'd0, vsm ? v6 : s6}; e32x = {32'd0, vsm ? v3 : s3}; end
        12'h31C: begin e64 = '0; e32x = {32'd0, m3[63:32]}; end
        12'h61C: begin e64 = '0; e32x = {32'd0, h3[63:32]}; end
        default: begin e64 = '0; e32x = '0; end
      endcase
      chk(me64 == m6 && he64 == h6 && se64 == s6 && ve64 == v6, "R10 eff64",
          me64 ^ he64, m6 ^ h6);
      chk(me32 == m3 && he32 == h3 && se32 == s3 && ve32 == v3, "R10 eff32",
          me32 ^ he32, m3 ^ h3);
      chk(rd64 == e64 && hit64 == eh64, "R10 rd64", rd64, e64);
      chk({32'd0, rd32} == e32x && hit32 == eh32, "R10 rd32", {32'd0, rd32}, e32x);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); #1;
    addr = a; wd = d; we = 1'b1;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk64(input logic [11:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk); #1;
    addr = a; we = 1'b0;
    #2;
    chk(rd64 == exp, tag, rd64, exp);
  endtask

  task automatic rd_chk32(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    addr = a; we = 1'b0;
    #2;
    chk(rd32 == exp, tag, {32'd0, rd32}, {32'd0, exp});
  endtask

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; addr = 12'h000; we = 1'b0; wd = '0;
    priv = 2'b11; virt = 1'b0; fon = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd_chk64(12'h30C, 64'd0, "R1 mach");
    rd_chk64(12'h60C, 64'd0, "R1 hyp");
    rd_chk64(12'h10C, 64'd0, "R1 sup");
    chk(me64 == 0 && he64 == 0 && se64 == 0, "R1 eff", me64, 64'd0);

    // R2 machine fields
    wr(12'h30C, '1);
    rd_chk64(12'h30C, 64'hDF00_0000_0000_0007, "R2 mach all ones");
    // R3 hypervisor fields
    wr(12'h60C, '1);
    rd_chk64(12'h60C, 64'hDE00_0000_0000_0007, "R3 hyp all ones");
    // R4 supervisor fields
    wr(12'h10C, '1);
    rd_chk64(12'h10C, 64'h7, "R4 sup all ones");

    // R5 virtualized supervisor view
    wr(12'h60C, 64'h8000_0000_0000_0001);
    rd_chk64(12'h60C, 64'h8000_0000_0000_0001, "R3 bit63 written");
    virt = 1'b1; priv = 2'b01;
    rd_chk64(12'h10C, 64'h1, "R5 vs view masked");
    chk(ve64 == 32'h1 && se64 == 32'h7, "R5 vs_eff", {32'd0, ve64}, 64'h1);
    priv = 2'b11;
    rd_chk64(12'h10C, 64'h7, "R5 virt in machine mode");
    virt = 1'b0; priv = 2'b01;
    rd_chk64(12'h10C, 64'h7, "R5 native view");

    // R6 FCSR read-only zero with F on
    fon = 1'b1;
    rd_chk64(12'h30C, 64'hDF00_0000_0000_0005, "R6 mach fcsr");
    rd_chk64(12'h10C, 64'h5, "R6 sup fcsr");
    fon = 1'b0;
    rd_chk64(12'h10C, 64'h7, "R6 fcsr back");

    // R7 values kept under masking
    wr(12'h30C, 64'h8000_0000_0000_0000);
    rd_chk64(12'h10C, 64'h0, "R7 sup masked");
    rd_chk64(12'h60C, 64'h8000_0000_0000_0000, "R7 hyp masked");
    wr(12'h30C, '1);
    rd_chk64(12'h10C, 64'h7, "R7 sup restored");
    rd_chk64(12'h60C, 64'h8000_0000_0000_0001, "R7 hyp restored");

    // R9 indices 1..3
    wr(12'h30D, 64'h0);
    wr(12'h60F, 64'h0);
    rd_chk64(12'h30E, 64'h0, "R9 index read");
    chk(hit64 == 1'b1, "R9 index hit", {63'd0, hit64}, 64'd1);
    rd_chk64(12'h30C, 64'hDF00_0000_0000_0007, "R9 mach untouched");
    rd_chk64(12'h60C, 64'h8000_0000_0000_0001, "R9 hyp untouched");

    // R8 high halves
    rd_chk64(12'h31C, 64'h0, "R8 rv64 no high half");
    chk(hit64 == 1'b0, "R8 rv64 hit", {63'd0, hit64}, 64'd0);
    chk(hit32 == 1'b1, "R8 rv32 hit", {63'd0, hit32}, 64'd1);
    wr(12'h31C, 64'hFFFF_FFFF);
    rd_chk32(12'h31C, 32'hDF00_0000, "R8 rv32 mach high");
    wr(12'h61C, 64'hFFFF_FFFF);
    rd_chk32(12'h61C, 32'hDE00_0000, "R8 rv32 hyp high");
    rd_chk64(12'h30C, 64'hDF00_0000_0000_0007, "R8 rv64 mach unaffected");

    // R11 unimplemented JVT in the 32-bit instance
    rd_chk32(12'h30C, 32'h3, "R11 mach jvt absent");
    rd_chk32(12'h10C, 32'h3, "R11 sup jvt absent");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule